// File: doc/BRIEF.md
# Byte-Masked Write Controller for a Word-Wide Cache Data Store

This block sits on the write path of a cache data store. The store is one word wide and matches the processor data path. Requests arrive one at a time on a valid/ready handshake. Each request carries a word address, a write flag, a data word and a four-bit byte strobe. A write with every strobe bit set goes into the store in a single access, with no read.

Any other non-empty strobe pattern starts a read-modify-write. In the cycle the request is accepted, the stored word is read. In the next cycle, only the strobed byte lanes are replaced and the word is written back. A write with no strobe bits set is acknowledged and nothing else happens. Reads return the stored word one cycle after they are accepted.

The store has a single port, so the controller withholds ready only in the write-back cycle, and only when another request is already waiting. A request that arrives after the write-back is accepted at once.

Top module: `rmw_sram_ctrl`

## Requirements
- R1: A write whose strobe is 4'b1111 performs one store write of the whole word and no store read, and leaves ready high in the following cycle.
- R2: A write with a strobe that is neither all ones nor all zeros reads the stored word in its acceptance cycle. It writes the word back in the next cycle. Strobe bit i selects bits 8*i+7 to 8*i: where the bit is set, the new data replaces those bits; where it is clear, the old value is kept.
- R3: Writing strobe 4'b1110 to word N keeps byte 0 of word N. Then writing strobe 4'b0001 to word N+1 keeps bytes 1 to 3 of word N+1.
- R4: A write with strobe 4'b0000 is accepted without stalling and performs no store access. The addressed word is unchanged, and a request right after it is not stalled.
- R5: A read accepted at one rising edge asserts rsp_valid for exactly one cycle after that edge, with the stored word on rsp_rdata. No other request asserts rsp_valid.
- R6: req_ready is low only in the write-back cycle of a read-modify-write, and only while req_valid is high. Two masked writes in consecutive cycles therefore stall the second one by exactly one cycle. Masked writes separated by one idle cycle never stall.
- R7: A read of the same word, issued right after a masked write, waits out the write-back and returns the merged word.
- R8: During and right after reset, req_ready is high and rsp_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted at this edge when valid is also high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 32 | Write data |
| req_strb | input | 4 | Byte strobe, bit i selects byte lane i |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |

## Verification
The situation that is hardest to reach is a collision with the one-cycle write-back window. A second request has to be presented in exactly the cycle after a masked write was accepted.

The driver task presents requests on consecutive cycles by default and inserts an idle cycle only when asked. Directed pairs (masked after masked, read after masked to the same word, masked with a gap) pin the stall count to one or zero. A long mixed sequence then hits the window with every request type. A shadow copy of the store, kept in the bench, predicts every read result.

// File: rtl/rmw_pkg.sv
`timescale 1ns/1ps
package rmw_pkg;
  localparam int WORD_W = 32;
  localparam int LANE_W = 8;
  localparam int LANES  = WORD_W / LANE_W;

  typedef enum logic [1:0] {WK_NULL, WK_PART, WK_FULL} wr_kind_e;
  typedef enum logic {ST_IDLE, ST_WB} rmw_state_e;

  function automatic wr_kind_e classify_strb(input logic [LANES-1:0] strb);
    if (&strb)      return WK_FULL;
    else if (|strb) return WK_PART;
    else            return WK_NULL;
  endfunction
endpackage

// File: rtl/rmw_store.sv
`timescale 1ns/1ps
module rmw_store #(
  parameter int ADDR_W = 8,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              re,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata <= mem[addr];
  end
endmodule

// File: rtl/rmw_merge.sv
`timescale 1ns/1ps
module rmw_merge #(
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic [LANES*LANE_W-1:0] old_word,
  input  logic [LANES*LANE_W-1:0] new_word,
  input  logic [LANES-1:0]        strb,
  output logic [LANES*LANE_W-1:0] merged
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign merged[l*LANE_W +: LANE_W] =
      strb[l] ? new_word[l*LANE_W +: LANE_W] : old_word[l*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/rmw_seq.sv
`timescale 1ns/1ps
module rmw_seq
  import rmw_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              part_wr_fire,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [WORD_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_strb,
  output logic              busy,
  output logic [ADDR_W-1:0] hold_addr,
  output logic [WORD_W-1:0] hold_wdata,
  output logic [LANES-1:0]  hold_strb
);
  rmw_state_e state;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      hold_addr  <= '0;
      hold_wdata <= '0;
      hold_strb  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (part_wr_fire) begin
          state      <= ST_WB;
          hold_addr  <= req_addr;
          hold_wdata <= req_wdata;
          hold_strb  <= req_strb;
        end
        ST_WB: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state == ST_WB);
endmodule

// File: rtl/rmw_sram_ctrl.sv
`timescale 1ns/1ps
module rmw_sram_ctrl
  import rmw_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  input  logic [3:0]        req_strb,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata
);
  wr_kind_e          kind;
  logic              accept;
  logic              full_wr_fire, part_wr_fire, null_wr_fire, rd_fire;
  logic              wb_fire;
  logic              sram_re, sram_we;
  logic [ADDR_W-1:0] sram_addr;
  logic [WORD_W-1:0] sram_wdata, sram_rdata, merged;
  logic [ADDR_W-1:0] hold_addr;
  logic [WORD_W-1:0] hold_wdata;
  logic [LANES-1:0]  hold_strb;

  assign kind         = classify_strb(req_strb);
  assign req_ready    = !(wb_fire && req_valid);
  assign accept       = req_valid && req_ready;
  assign full_wr_fire = accept && req_write && (kind == WK_FULL);
  assign part_wr_fire = accept && req_write && (kind == WK_PART);
  assign null_wr_fire = accept && req_write && (kind == WK_NULL);
  assign rd_fire      = accept && !req_write;

  rmw_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk, .rst_n, .part_wr_fire, .req_addr, .req_wdata, .req_strb,
    .busy(wb_fire), .hold_addr, .hold_wdata, .hold_strb
  );

  rmw_merge #(.LANES(LANES), .LANE_W(LANE_W)) u_merge (
    .old_word(sram_rdata), .new_word(hold_wdata), .strb(hold_strb), .merged
  );

  assign sram_re    = part_wr_fire || rd_fire;
  assign sram_we    = full_wr_fire || wb_fire;
  assign sram_addr  = wb_fire ? hold_addr : req_addr;
  assign sram_wdata = wb_fire ? merged : req_wdata;

  rmw_store #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_store (
    .clk, .re(sram_re), .we(sram_we), .addr(sram_addr),
    .wdata(sram_wdata), .rdata(sram_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) rsp_valid <= 1'b0;
    else        rsp_valid <= rd_fire;
  end
  assign rsp_rdata = sram_rdata;
endmodule

// File: rtl/rmw_sram_ctrl_chk.sv
`timescale 1ns/1ps
module rmw_sram_ctrl_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic              full_wr_fire,
  input logic              part_wr_fire,
  input logic              null_wr_fire,
  input logic              rd_fire,
  input logic              wb_fire,
  input logic              sram_re,
  input logic              sram_we,
  input logic [ADDR_W-1:0] sram_addr,
  input logic              rsp_valid
);
  a_r1_full_single: assert property (@(posedge clk) disable iff (!rst_n)
    full_wr_fire |-> (sram_we && !sram_re));
  a_r1_full_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
    full_wr_fire |=> !wb_fire);
  a_r2_read_first: assert property (@(posedge clk) disable iff (!rst_n)
    part_wr_fire |-> (sram_re && !sram_we));
  a_r2_wb_next: assert property (@(posedge clk) disable iff (!rst_n)
    part_wr_fire |=> (wb_fire && sram_we && sram_addr == $past(req_addr)));
  a_r2_wb_once: assert property (@(posedge clk) disable iff (!rst_n)
    wb_fire |=> !wb_fire);
  a_r4_null_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    null_wr_fire |-> (!sram_we && !sram_re));
  a_r5_rsp_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> rsp_valid);
  a_r5_rsp_only_read: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_fire |=> !rsp_valid);
  a_r6_ready_outside_wb: assert property (@(posedge clk) disable iff (!rst_n)
    !wb_fire |-> req_ready);
  a_r6_idle_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> req_ready);
  a_r7_no_read_in_wb: assert property (@(posedge clk) disable iff (!rst_n)
    wb_fire |-> !rd_fire);
endmodule

bind rmw_sram_ctrl rmw_sram_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .full_wr_fire(full_wr_fire), .part_wr_fire(part_wr_fire),
  .null_wr_fire(null_wr_fire), .rd_fire(rd_fire), .wb_fire(wb_fire),
  .sram_re(sram_re), .sram_we(sram_we), .sram_addr(sram_addr),
  .rsp_valid(rsp_valid)
);

// File: tb/rmw_sram_ctrl_test.sv
`timescale 1ns/1ps
module rmw_sram_ctrl_test;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0]   req_wdata = '0;
  logic [3:0]    req_strb = '0;
  logic          rsp_valid;
  logic [31:0]   rsp_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [31:0] shadow [1 << AW];
  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #5 clk = ~clk;

  rmw_sram_ctrl #(.ADDR_W(AW)) uut (
    .clk, .rst_n, .req_valid, .req_ready, .req_write, .req_addr,
    .req_wdata, .req_strb, .rsp_valid, .rsp_rdata
  );

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // Drives one request and returns the number of cycles it waited for ready.
  task automatic send(input logic wr, input logic [AW-1:0] a, input logic [31:0] d,
                      input logic [3:0] s, input string rq, output int stalls);
    stalls = 0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_strb = s;
    #1;
    while (!req_ready) begin
      stalls++;
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    if (wr) begin
      for (int b = 0; b < 4; b++)
        if (s[b]) shadow[a][8*b +: 8] = d[8*b +: 8];
    end else begin
      exp_q.push_back(shadow[a]);
      tag_q.push_back(rq);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d, input logic [3:0] s,
                    input string rq, input int exp_stall);
    int st;
    send(1'b1, a, d, s, rq, st);
    if (exp_stall >= 0) check({rq, " stall"}, st, exp_stall);
  endtask

  task automatic rd(input logic [AW-1:0] a, input string rq, input int exp_stall);
    int st;
    send(1'b0, a, '0, '0, rq, st);
    if (exp_stall >= 0) check({rq, " stall"}, st, exp_stall);
  endtask

  // Monitor: compare each response with the scoreboard head.
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R5 unexpected response actual=%h expected=none", rsp_rdata);
      end else begin
        string t;
        logic [31:0] e;
        t = tag_q.pop_front();
        e = exp_q.pop_front();
        check(t, rsp_rdata, e);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    repeat (2) @(negedge clk);
    check("R8 ready in reset", {31'd0, req_ready}, 32'd1);
    check("R8 rsp_valid in reset", {31'd0, rsp_valid}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 ready after reset", {31'd0, req_ready}, 32'd1);
    check("R8 rsp_valid after reset", {31'd0, rsp_valid}, 32'd0);

    // R1: full writes back to back, never stalled.
    for (int i = 0; i < 32; i++)
      wr(AW'(i), 32'h1000_0000 + 32'(i) * 32'h0101_0101, 4'hF, "R1", 0);
    for (int i = 0; i < 32; i++) rd(AW'(i), "R1 R5", 0);

    // R2: single masked write.
    wr(8'd3, 32'hA5B6C7D8, 4'b0110, "R2", 0);
    repeat (2) @(posedge clk);
    rd(8'd3, "R2", 0);

    // R3: write spanning a word boundary.
    wr(8'h40, 32'h11223344, 4'hF, "R3", -1);
    wr(8'h41, 32'h55667788, 4'hF, "R3", -1);
    wr(8'h40, 32'hAABBCC00, 4'b1110, "R3", 0);
    wr(8'h41, 32'h000000DD, 4'b0001, "R3", 1);
    rd(8'h40, "R3 word N", 1);
    rd(8'h41, "R3 word N+1", 0);

    // R4: empty strobe.
    wr(8'd5, 32'hDEADBEEF, 4'b0000, "R4", 0);
    wr(8'd6, 32'h0000EE00, 4'b0010, "R4", 0);
    rd(8'd5, "R4 unchanged", 1);

    // R6: consecutive masked writes stall once; a gap removes the stall.
    wr(8'd7, 32'h000000AB, 4'b0001, "R6", 0);
    wr(8'd8, 32'hCD000000, 4'b1000, "R6", 1);
    @(posedge clk);
    wr(8'd9, 32'h00FF0000, 4'b0100, "R6", 0);
    @(posedge clk);
    wr(8'd10, 32'h12340000, 4'b1100, "R6", 0);
    wr(8'd11, 32'hFFFFFFFF, 4'hF, "R6", 1);

    // R7: read right behind a masked write to the same word.
    wr(8'd12, 32'h0077_0000, 4'b0100, "R7", 0);
    rd(8'd12, "R7 merged", 1);

    // Mixed sequence over words 0..31.
    lfsr = 16'hACE1;
    for (int n = 0; n < 400; n++) begin
      logic [3:0] s;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      s = lfsr[3:0];
      if (lfsr[5:4] == 2'b00) rd(AW'(lfsr[10:6]), "R5 mixed", -1);
      else wr(AW'(lfsr[10:6]), {lfsr, ~lfsr}, s, "R2 mixed", -1);
      if (lfsr[11]) @(posedge clk);
    end
    for (int i = 0; i < 32; i++) rd(AW'(i), "R2 final", -1);

    repeat (4) @(posedge clk);
    check("R5 all answered", exp_q.size(), 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule